// File: doc/BRIEF.md
# E1 CAS Signaling Receiver with Freeze

This block consumes the time-slot-16 octet of every frame of an already frame-aligned E1 stream. From those octets it locks onto the 16-frame channel-associated signaling multiframe. It reports the spare bits and the distant-end multiframe alarm carried in frame 0, and it flags signaling AIS when the slot is almost entirely ones. It also keeps a 4-bit ABCD value for each of the 30 voice channels, which a plain read port can look up at any time. The octet can come from the line side or from a system-side signaling input, chosen by a select pin.

Stored signaling is protected by a freeze state. When freeze is active, no stored ABCD value changes. Freeze comes on by itself when any of these happens: loss of signal, loss of multiframe alignment, or a receive slip. After a resynchronization or a slip, freeze stays on until one complete multiframe has arrived, so the values that can be read are never from a partial multiframe. A resync pulse tells the surroundings that alignment was regained. A control pin turns the automatic freeze off.

The octet input uses a valid/ready handshake. Ready is held high at all times, so the block never applies back-pressure. Every cycle with valid high delivers exactly one frame's octet, and octets arrive in frame order. The source may leave gaps between octets by holding valid low.

Top module: `cas_rx_ctrl`

## Requirements
- R1: `in_ready` is always 1. Each cycle with `in_valid` high accepts one octet, taken from `sys_ts16` when `use_sys` is 1 and from `line_ts16` otherwise.
- R2: While unaligned, an accepted octet whose upper nibble (bits 7:4) is 0000 declares alignment, provided the previously accepted octet's upper nibble was not 0000. That octet becomes frame 0. Directly after reset, the "previous octet" counts as having carried 0000.
- R3: While aligned, frames count 0..15 on accepted octets. A single frame-0 octet with a nonzero upper nibble keeps alignment. Two such octets in consecutive multiframes drop `mf_aligned` in the cycle after the second one.
- R4: `resync_irq` is high for exactly one cycle, the cycle after the octet that declared alignment.
- R5: In a frame-0 octet, bit 3 is X1, bit 2 is Y and bits 1 and 0 are X2 and X3. On alignment and on every good frame-0 octet, `spare_x` = {X1,X2,X3} and `remote_alarm` = Y.
- R6: In aligned frame f (1 to 15), the upper nibble is the ABCD of channel f and the lower nibble is the ABCD of channel f+15. `rd_abcd` returns the stored value of channel `rd_ch` (1 to 30) combinationally, and 0 for any other index.
- R7: `freeze` = not `freeze_dis` and (`los` or `slip` or not aligned or a pending hold). While `freeze` is 1, no stored ABCD value changes.
- R8: A resynchronization or a `slip` pulse sets a pending hold. The hold clears only when a good frame-0 octet is accepted with no slip in that cycle, so the first multiframe after resync is never stored.
- R9: With `freeze_dis` high, `freeze` is 0 and aligned frames update the store even during `los`.
- R10: Accepted octets form blocks of 16 counted from reset. At the end of each block, `sig_ais` becomes 1 if the last two blocks together held fewer than 3 zero bits, and 0 otherwise.
- R11: After reset, `mf_aligned`, `resync_irq`, `sig_ais`, `remote_alarm`, `spare_x` and every stored ABCD value are 0, and `freeze` is 1 unless `freeze_dis` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One TS16 octet offered this cycle |
| in_ready | output | 1 | Always 1; the block never stalls |
| line_ts16 | input | 8 | TS16 octet from the line side |
| sys_ts16 | input | 8 | TS16 octet from the system-side signaling input |
| use_sys | input | 1 | 1 selects the system-side octet |
| los | input | 1 | Loss of signal flag |
| slip | input | 1 | Receive slip pulse |
| freeze_dis | input | 1 | 1 disables automatic freeze |
| rd_ch | input | 5 | Channel number to read, 1 to 30 |
| rd_abcd | output | 4 | Stored ABCD of the addressed channel |
| mf_aligned | output | 1 | CAS multiframe alignment held |
| freeze | output | 1 | Freeze state; stored signaling is not updated |
| resync_irq | output | 1 | One-cycle pulse on alignment regained |
| sig_ais | output | 1 | Signaling AIS detected |
| remote_alarm | output | 1 | Y bit of the last good frame-0 octet |
| spare_x | output | 3 | {X1,X2,X3} of the last good frame-0 octet |

## Verification
A frame counter that slips by even one position shows up right away. Every ABCD nibble then lands in the wrong channel, which is visible on `rd_abcd` once that multiframe ends. At the next frame 0 the bad alignment check also fires, and two multiframes later `mf_aligned` drops. A pending hold that gets stuck or is lost shows up either as `freeze` staying high after a good frame 0, or as channels changing during the first multiframe after resync. Both can be seen within one multiframe of 16 octets. A miscounted zero tally in the AIS detector shifts `sig_ais` at the next 16-octet block boundary.

// File: rtl/cas_rx_pkg.sv
package cas_rx_pkg;
  localparam int OCTET_W = 8;
  localparam int NIB_W   = 4;

  function automatic logic [3:0] zero_bits(input logic [OCTET_W-1:0] b);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < OCTET_W; i++) begin
      if (!b[i]) n = n + 4'd1;
    end
    return n;
  endfunction
endpackage

// File: rtl/cas_mf_align.sv
module cas_mf_align
  import cas_rx_pkg::*;
#(
  parameter int MF_LEN    = 16,
  parameter int BAD_LIMIT = 2,
  localparam int FW = $clog2(MF_LEN),
  localparam int BW = $clog2(BAD_LIMIT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vld,
  input  logic [OCTET_W-1:0] octet,
  input  logic               slip,
  output logic               aligned,
  output logic [FW-1:0]      fcnt,
  output logic               pend,
  output logic               resync,
  output logic [2:0]         x_bits,
  output logic               y_bit
);
  logic          prev_zero;
  logic [BW-1:0] bad_q;
  logic          zero_nib;

  assign zero_nib = (octet[7:4] == 4'b0000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aligned   <= 1'b0;
      fcnt      <= '0;
      bad_q     <= '0;
      prev_zero <= 1'b1;
      pend      <= 1'b0;
      resync    <= 1'b0;
      x_bits    <= '0;
      y_bit     <= 1'b0;
    end else begin
      resync <= 1'b0;
      if (vld) begin
        prev_zero <= zero_nib;
        if (!aligned) begin
          if (zero_nib && !prev_zero) begin
            aligned <= 1'b1;
            fcnt    <= FW'(1);
            bad_q   <= '0;
            resync  <= 1'b1;
            pend    <= 1'b1;
            x_bits  <= {octet[3], octet[1], octet[0]};
            y_bit   <= octet[2];
          end
        end else begin
          fcnt <= (fcnt == FW'(MF_LEN - 1)) ? '0 : fcnt + FW'(1);
          if (fcnt == '0) begin
            if (zero_nib) begin
              bad_q  <= '0;
              pend   <= 1'b0;
              x_bits <= {octet[3], octet[1], octet[0]};
              y_bit  <= octet[2];
            end else if (bad_q == BW'(BAD_LIMIT - 1)) begin
              aligned <= 1'b0;
              bad_q   <= '0;
            end else begin
              bad_q <= bad_q + BW'(1);
            end
          end
        end
      end
      if (slip) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/cas_ais_det.sv
module cas_ais_det
  import cas_rx_pkg::*;
#(
  parameter int MF_LEN     = 16,
  parameter int ZERO_LIMIT = 3,
  localparam int FW = $clog2(MF_LEN),
  localparam int CW = $clog2(ZERO_LIMIT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vld,
  input  logic [OCTET_W-1:0] octet,
  output logic               ais
);
  logic [FW-1:0] blk_q;
  logic [CW-1:0] cur_q, prev_q, cur_next;
  int            sum;

  always_comb begin
    sum = int'(cur_q) + int'(zero_bits(octet));
    cur_next = (sum > ZERO_LIMIT) ? CW'(ZERO_LIMIT) : CW'(sum);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q  <= '0;
      cur_q  <= '0;
      prev_q <= CW'(ZERO_LIMIT);
      ais    <= 1'b0;
    end else if (vld) begin
      blk_q <= (blk_q == FW'(MF_LEN - 1)) ? '0 : blk_q + FW'(1);
      if (blk_q == FW'(MF_LEN - 1)) begin
        ais    <= (int'(prev_q) + int'(cur_next)) < ZERO_LIMIT;
        prev_q <= cur_next;
        cur_q  <= '0;
      end else begin
        cur_q <= cur_next;
      end
    end
  end
endmodule

// File: rtl/cas_sig_store.sv
module cas_sig_store
  import cas_rx_pkg::*;
#(
  parameter int NUM_CH = 30,
  parameter int FW     = 4,
  parameter int CH_W   = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [FW-1:0]           fcnt,
  input  logic [OCTET_W-1:0]      octet,
  input  logic [CH_W-1:0]         rd_ch,
  output logic [NIB_W-1:0]        rd_abcd,
  output logic [NUM_CH*NIB_W-1:0] flat
);
  localparam int HALF = NUM_CH / 2;

  logic [NIB_W-1:0] mem [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int  FR = (c < HALF) ? c + 1 : c + 1 - HALF;
    localparam bit  UP = (c < HALF);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem[c] <= '0;
      end else if (wr_en && fcnt == FW'(FR)) begin
        mem[c] <= UP ? octet[7:4] : octet[3:0];
      end
    end
    assign flat[c*NIB_W +: NIB_W] = mem[c];
  end

  always_comb begin
    rd_abcd = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_ch == CH_W'(i + 1)) rd_abcd = mem[i];
    end
  end
endmodule

// File: rtl/cas_rx_ctrl.sv
module cas_rx_ctrl
  import cas_rx_pkg::*;
#(
  parameter int NUM_CH     = 30,
  parameter int BAD_LIMIT  = 2,
  parameter int ZERO_LIMIT = 3,
  localparam int MF_LEN = NUM_CH / 2 + 1,
  localparam int FW     = $clog2(MF_LEN),
  localparam int CH_W   = $clog2(NUM_CH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [OCTET_W-1:0] line_ts16,
  input  logic [OCTET_W-1:0] sys_ts16,
  input  logic               use_sys,
  input  logic               los,
  input  logic               slip,
  input  logic               freeze_dis,
  input  logic [CH_W-1:0]    rd_ch,
  output logic [NIB_W-1:0]   rd_abcd,
  output logic               mf_aligned,
  output logic               freeze,
  output logic               resync_irq,
  output logic               sig_ais,
  output logic               remote_alarm,
  output logic [2:0]         spare_x
);
  logic [OCTET_W-1:0]      octet;
  logic [FW-1:0]           fcnt;
  logic                    pend;
  logic                    wr_en;
  logic [NUM_CH*NIB_W-1:0] store_flat;

  assign in_ready = 1'b1;
  assign octet    = use_sys ? sys_ts16 : line_ts16;
  assign freeze   = !freeze_dis && (los || slip || !mf_aligned || pend);
  assign wr_en    = in_valid && mf_aligned && (fcnt != '0) && !freeze;

  cas_mf_align #(.MF_LEN(MF_LEN), .BAD_LIMIT(BAD_LIMIT)) u_align (
    .clk(clk), .rst_n(rst_n), .vld(in_valid), .octet(octet), .slip(slip),
    .aligned(mf_aligned), .fcnt(fcnt), .pend(pend), .resync(resync_irq),
    .x_bits(spare_x), .y_bit(remote_alarm)
  );

  cas_ais_det #(.MF_LEN(MF_LEN), .ZERO_LIMIT(ZERO_LIMIT)) u_ais (
    .clk(clk), .rst_n(rst_n), .vld(in_valid), .octet(octet), .ais(sig_ais)
  );

  cas_sig_store #(.NUM_CH(NUM_CH), .FW(FW), .CH_W(CH_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .fcnt(fcnt), .octet(octet),
    .rd_ch(rd_ch), .rd_abcd(rd_abcd), .flat(store_flat)
  );
endmodule

// File: rtl/cas_rx_chk.sv
module cas_rx_chk #(
  parameter int W = 120
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         aligned,
  input logic         freeze,
  input logic         freeze_dis,
  input logic         irq,
  input logic [W-1:0] store_flat
);
  assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_irq_on_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (aligned && !$past(aligned)));
  assert_loss_on_octet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aligned) |-> $past(in_valid));
  assert_frozen_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(store_flat));
  assert_open_needs_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !freeze_dis) |-> aligned);
  assert_resync_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !freeze_dis) |-> freeze);
  assert_disable_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_dis |-> !freeze);
endmodule

bind cas_rx_ctrl cas_rx_chk #(.W(NUM_CH * 4)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .aligned(mf_aligned),
  .freeze(freeze), .freeze_dis(freeze_dis), .irq(resync_irq),
  .store_flat(store_flat)
);

// File: tb/cas_rx_ctrl_tb.sv
`timescale 1ns/1ps
module cas_rx_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] line_ts16 = 8'h00;
  logic [7:0] sys_ts16 = 8'h00;
  logic       use_sys = 1'b0;
  logic       los = 1'b0;
  logic       slip = 1'b0;
  logic       freeze_dis = 1'b0;
  logic [4:0] rd_ch = 5'd0;
  logic [3:0] rd_abcd;
  logic       mf_aligned, freeze, resync_irq, sig_ais, remote_alarm;
  logic [2:0] spare_x;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cas_rx_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .line_ts16(line_ts16), .sys_ts16(sys_ts16), .use_sys(use_sys),
    .los(los), .slip(slip), .freeze_dis(freeze_dis), .rd_ch(rd_ch),
    .rd_abcd(rd_abcd), .mf_aligned(mf_aligned), .freeze(freeze),
    .resync_irq(resync_irq), .sig_ais(sig_ais), .remote_alarm(remote_alarm),
    .spare_x(spare_x)
  );

  // {octet, aligned, irq, freeze} after each accepted octet
  localparam logic [10:0] TBL [19] = '{
    {8'h0B, 3'b001}, {8'hFF, 3'b001}, {8'h0B, 3'b111},
    {8'h1E, 3'b101}, {8'h2D, 3'b101}, {8'h3C, 3'b101}, {8'h4B, 3'b101},
    {8'h5A, 3'b101}, {8'h69, 3'b101}, {8'h78, 3'b101}, {8'h87, 3'b101},
    {8'h96, 3'b101}, {8'hA5, 3'b101}, {8'hB4, 3'b101}, {8'hC3, 3'b101},
    {8'hD2, 3'b101}, {8'hE1, 3'b101}, {8'hF0, 3'b101}, {8'h09, 3'b100}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    line_ts16 = b;
    in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic frames(input bit swap);
    for (int f = 1; f < 16; f++) begin
      logic [3:0] n;
      n = 4'(f);
      push(swap ? {~n, n} : {n, ~n});
    end
  endtask

  task automatic rd(input string req, input int ch, input logic [3:0] exp);
    rd_ch = 5'(ch);
    #1 chk(req, {4'h0, rd_abcd}, {4'h0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 aligned", {7'd0, mf_aligned}, 8'd0);
    chk("R11 freeze", {7'd0, freeze}, 8'd1);
    chk("R11 irq", {7'd0, resync_irq}, 8'd0);
    chk("R11 ais", {7'd0, sig_ais}, 8'd0);
    rd("R11 store", 1, 4'h0);
    @(negedge clk) rst_n = 1'b1;
    #1 chk("R1 ready", {7'd0, in_ready}, 8'd1);

    // R2 R4 R8: table walk
    for (int i = 0; i < 19; i++) begin
      push(TBL[i][10:3]);
      chk("R2 aligned", {7'd0, mf_aligned}, {7'd0, TBL[i][2]});
      chk("R4 irq", {7'd0, resync_irq}, {7'd0, TBL[i][1]});
      chk("R8 freeze", {7'd0, freeze}, {7'd0, TBL[i][0]});
    end
    chk("R5 spare_x", {5'd0, spare_x}, 8'd5);
    chk("R5 rai", {7'd0, remote_alarm}, 8'd0);
    rd("R8 first mf frozen", 1, 4'h0);
    rd("R8 first mf frozen", 16, 4'h0);

    // R6 mapping
    frames(1'b0);
    push(8'h09);
    rd("R6 ch5", 5, 4'h5);
    rd("R6 ch15", 15, 4'hF);
    rd("R6 ch16", 16, 4'hE);
    rd("R6 ch20", 20, 4'hA);
    rd("R6 ch31", 31, 4'h0);
    chk("R10 ais clear", {7'd0, sig_ais}, 8'd0);

    // R7 los freeze
    @(negedge clk) los = 1'b1;
    #1 chk("R7 los freeze", {7'd0, freeze}, 8'd1);
    frames(1'b1);
    los = 1'b0;
    push(8'h0C);
    rd("R7 held", 5, 4'h5);
    chk("R5 rai", {7'd0, remote_alarm}, 8'd1);
    chk("R5 spare_x", {5'd0, spare_x}, 8'd4);
    chk("R7 freeze off", {7'd0, freeze}, 8'd0);

    // R8 slip hold
    @(negedge clk) slip = 1'b1;
    #1 chk("R7 slip freeze", {7'd0, freeze}, 8'd1);
    @(negedge clk) slip = 1'b0;
    frames(1'b1);
    rd("R8 slip held", 5, 4'h5);
    chk("R8 slip pending", {7'd0, freeze}, 8'd1);
    push(8'h09);
    chk("R8 hold cleared", {7'd0, freeze}, 8'd0);
    frames(1'b1);
    push(8'h09);
    rd("R8 update ch5", 5, 4'hA);
    rd("R8 update ch20", 20, 4'h5);

    // R9 auto freeze disabled
    @(negedge clk) begin freeze_dis = 1'b1; los = 1'b1; end
    #1 chk("R9 no freeze", {7'd0, freeze}, 8'd0);
    frames(1'b0);
    push(8'h09);
    rd("R9 updates under los", 5, 4'h5);
    @(negedge clk) begin freeze_dis = 1'b0; los = 1'b0; end

    // R3 alignment loss
    frames(1'b0);
    push(8'hFF);
    chk("R3 one bad kept", {7'd0, mf_aligned}, 8'd1);
    for (int i = 0; i < 15; i++) push(8'h55);
    push(8'hFF);
    chk("R3 two bad lost", {7'd0, mf_aligned}, 8'd0);
    chk("R7 unaligned freeze", {7'd0, freeze}, 8'd1);

    // R2 R4 realign
    push(8'h0C);
    chk("R2 realign", {7'd0, mf_aligned}, 8'd1);
    chk("R4 irq pulse", {7'd0, resync_irq}, 8'd1);
    push(8'h11);
    chk("R4 irq single", {7'd0, resync_irq}, 8'd0);

    // R10 R1 AIS from system side
    @(negedge clk) begin use_sys = 1'b1; sys_ts16 = 8'hFF; end
    for (int i = 0; i < 48; i++) push(8'h00);
    chk("R10 R1 ais set", {7'd0, sig_ais}, 8'd1);
    @(negedge clk) use_sys = 1'b0;
    for (int i = 0; i < 32; i++) push(8'h00);
    chk("R10 ais clear", {7'd0, sig_ais}, 8'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule